// File: doc/BRIEF.md
# Gated Edge Counter with Run Statistics

This block counts the rising edges of a slow divided oscillator clock over a measurement window. The window is a whole number of reference-clock cycles long. At the end of each window the count is compared with a nominal count, which is the count expected when the oscillator has not moved. The signed difference is reported on a one-cycle strobe. The divided clock arrives without any timing relation to the reference clock. It is resynchronised, and each of its rising edges becomes a single-cycle event in the reference domain.

A host repeats the measurement many times and then reads the accumulated figures: the smallest and largest difference, their spread, the running sum and the number of runs. The host forms the mean of the differences and their peak-to-peak spread from these values. A dedicated clear input restarts the accumulation without disturbing a window that is in progress.

Top module: `gated_edge_stats`

## Requirements
- R1: After reset, `run_valid` is 0, `run_diff` is 0, `stat_runs` and `stat_sum` are 0, `stat_min` holds the most positive value (2^(DIF_W-1)-1), `stat_max` holds the most negative value (-2^(DIF_W-1)), and `stat_spread` is 0.
- R2: A `start` sampled high on a clock edge opens a window. `run_valid` is high for exactly one cycle, `win_len` clock edges after that edge.
- R3: `run_diff` equals the number of counted edges minus `nominal`, as a two's complement value, and it may be negative.
- R4: Each rising edge of `div_clk` that reaches the reference domain while a window is open adds exactly one to the count. Edges that arrive while no window is open are not counted.
- R5: A `start` during an open window abandons that window without a result. It clears the count and opens a new window of the newly given length.
- R6: A `start` with `win_len` equal to 0 opens a window of the default length DEF_WIN, which is 16384 cycles.
- R7: On the clock edge that follows a `run_valid` pulse, `stat_runs` increases by one and `run_diff` is added to the sign-extended `stat_sum`. Otherwise both hold their values.
- R8: `stat_min` and `stat_max` hold the smallest and largest `run_diff` seen since the last clear. `stat_spread` equals `stat_max - stat_min`, and it is 0 while `stat_runs` is 0.
- R9: `clear` sampled high returns all statistics to their R1 values on the next edge. This holds even when a result arrives in the same cycle, in which case that result is dropped from the statistics.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all state is in this domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_clk | input | 1 | Divided oscillator clock, unrelated to the reference |
| start | input | 1 | Opens (or reopens) a measurement window |
| clear | input | 1 | Resets the accumulated statistics |
| win_len | input | WIN_W | Window length in reference cycles; 0 selects DEF_WIN |
| nominal | input | CNT_W | Count expected with no frequency deviation |
| run_diff | output | DIF_W | Signed count minus nominal for the last window |
| run_valid | output | 1 | One-cycle strobe marking a new `run_diff` |
| stat_min | output | DIF_W | Smallest difference since clear (signed) |
| stat_max | output | DIF_W | Largest difference since clear (signed) |
| stat_sum | output | SUM_W | Signed sum of differences since clear |
| stat_runs | output | RUN_W | Number of results absorbed since clear |
| stat_spread | output | DIF_W+1 | Maximum minus minimum, 0 with no runs |

## Verification
Some rules are checked on every cycle. The synchronised edge strobe never lasts two cycles. The count steps by at most one and stays frozen while no window is open. An open window never has a zero timer, and a result never appears while the window stays open. The run counter advances only when a result is absorbed, a clear always leaves the preset values, and the minimum never exceeds the maximum once a run has been recorded. Other behaviours only show in the bench's scenarios: the exact cycle of each strobe, the signed value of each difference, the effect of a restart on an open window, the default length selected by a zero length, and a clear that collides with an arriving result.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;

endpackage

// File: rtl/ewc_edge_sync.sv
module ewc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic               synced;
  logic               synced_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-2:0], async_in};
  end

  assign synced      = chain_q[SYNC_STAGES-1];
  assign synced_prev = chain_q[SYNC_STAGES];
  assign rise_o      = synced & ~synced_prev;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R4

endmodule

// File: rtl/ewc_window.sv
module ewc_window
  import ewc_pkg::*;
#(
  parameter int WIN_W   = 16,
  parameter int CNT_W   = 17,
  parameter int DIF_W   = 18,
  parameter int DEF_WIN = 16384
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [WIN_W-1:0]        win_len,
  input  logic [CNT_W-1:0]        nominal,
  input  logic                    rise,
  output logic signed [DIF_W-1:0] res_diff,
  output logic                    res_valid
);

  localparam logic [WIN_W-1:0] DEF_LEN  = WIN_W'(DEF_WIN);
  localparam logic [WIN_W-1:0] LAST_CYC = WIN_W'(1);

  win_state_e       state_q;
  logic [WIN_W-1:0] timer_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_next;
  logic [WIN_W-1:0] load_len;
  logic             launch;
  logic             win_open;
  logic             closing;

  function automatic logic signed [DIF_W-1:0] run_delta(
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] nom
  );
    logic signed [DIF_W-1:0] a;
    logic signed [DIF_W-1:0] b;
    a = $signed({1'b0, cnt});
    b = $signed({1'b0, nom});
    return a - b;
  endfunction

  assign launch     = start;
  assign load_len   = (win_len == '0) ? DEF_LEN : win_len;
  assign win_open   = (state_q == WIN_OPEN);
  assign closing    = win_open && (timer_q == LAST_CYC) && !launch;
  assign count_next = count_q + CNT_W'(rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WIN_IDLE;
      timer_q   <= '0;
      count_q   <= '0;
      res_diff  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (launch) begin
        state_q <= WIN_OPEN;
        timer_q <= load_len;
        count_q <= '0;
      end else if (win_open) begin
        count_q <= count_next;
        if (closing) begin
          state_q   <= WIN_IDLE;
          timer_q   <= '0;
          res_valid <= 1'b1;
          res_diff  <= run_delta(count_next, nominal);
        end else begin
          timer_q <= timer_q - LAST_CYC;
        end
      end
    end
  end

  AST_TIMER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> timer_q != '0); // R2

  AST_VALID_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !win_open); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && $past(win_open) && !$past(launch)) |->
      (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1))); // R4

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !$past(win_open) && !$past(launch)) |-> $stable(count_q)); // R4

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (win_open && count_q == '0)); // R5

endmodule

// File: rtl/ewc_stats.sv
module ewc_stats #(
  parameter int DIF_W     = 18,
  parameter int RUNS_LOG2 = 16,
  parameter int SUM_W     = DIF_W + RUNS_LOG2,
  parameter int RUN_W     = RUNS_LOG2 + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    res_valid,
  input  logic signed [DIF_W-1:0] res_diff,
  output logic signed [DIF_W-1:0] st_min,
  output logic signed [DIF_W-1:0] st_max,
  output logic signed [SUM_W-1:0] st_sum,
  output logic [RUN_W-1:0]        st_runs,
  output logic [DIF_W:0]          st_spread
);

  localparam logic signed [DIF_W-1:0] MAXV = {1'b0, {(DIF_W-1){1'b1}}};
  localparam logic signed [DIF_W-1:0] MINV = {1'b1, {(DIF_W-1){1'b0}}};

  logic absorb;

  function automatic logic signed [SUM_W-1:0] widen(input logic signed [DIF_W-1:0] d);
    return {{(SUM_W-DIF_W){d[DIF_W-1]}}, d};
  endfunction

  function automatic logic [DIF_W:0] span(
    input logic signed [DIF_W-1:0] lo,
    input logic signed [DIF_W-1:0] hi
  );
    logic signed [DIF_W:0] l;
    logic signed [DIF_W:0] h;
    l = {lo[DIF_W-1], lo};
    h = {hi[DIF_W-1], hi};
    return h - l;
  endfunction

  assign absorb    = res_valid && !clear;
  assign st_spread = (st_runs == '0) ? '0 : span(st_min, st_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_min  <= MAXV;
      st_max  <= MINV;
      st_sum  <= '0;
      st_runs <= '0;
    end else if (clear) begin
      st_min  <= MAXV;
      st_max  <= MINV;
      st_sum  <= '0;
      st_runs <= '0;
    end else if (absorb) begin
      if (res_diff < st_min) st_min <= res_diff;
      if (res_diff > st_max) st_max <= res_diff;
      st_sum  <= st_sum + widen(res_diff);
      st_runs <= st_runs + RUN_W'(1);
    end
  end

  AST_CLEAR_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> (st_runs == '0 && st_sum == '0 && st_min == MAXV && st_max == MINV)); // R9

  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(absorb) |-> st_runs == $past(st_runs) + RUN_W'(1)); // R7

  AST_STATS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(absorb) && !$past(clear)) |-> ($stable(st_runs) && $stable(st_sum))); // R7

  AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (st_runs != '0) |-> st_min <= st_max); // R8

endmodule

// File: rtl/gated_edge_stats.sv
module gated_edge_stats #(
  parameter int WIN_W       = 16,
  parameter int DEF_WIN     = 16384,
  parameter int RUNS_LOG2   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = WIN_W + 1,
  parameter int DIF_W       = CNT_W + 1,
  parameter int SUM_W       = DIF_W + RUNS_LOG2,
  parameter int RUN_W       = RUNS_LOG2 + 1
) (
  input  logic                    clk_ref,
  input  logic                    rst_n,
  input  logic                    div_clk,
  input  logic                    start,
  input  logic                    clear,
  input  logic [WIN_W-1:0]        win_len,
  input  logic [CNT_W-1:0]        nominal,
  output logic signed [DIF_W-1:0] run_diff,
  output logic                    run_valid,
  output logic signed [DIF_W-1:0] stat_min,
  output logic signed [DIF_W-1:0] stat_max,
  output logic signed [SUM_W-1:0] stat_sum,
  output logic [RUN_W-1:0]        stat_runs,
  output logic [DIF_W:0]          stat_spread
);

  logic div_rise;

  ewc_edge_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .async_in (div_clk),
    .rise_o   (div_rise)
  );

  ewc_window #(
    .WIN_W   (WIN_W),
    .CNT_W   (CNT_W),
    .DIF_W   (DIF_W),
    .DEF_WIN (DEF_WIN)
  ) u_window (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .start     (start),
    .win_len   (win_len),
    .nominal   (nominal),
    .rise      (div_rise),
    .res_diff  (run_diff),
    .res_valid (run_valid)
  );

  ewc_stats #(
    .DIF_W     (DIF_W),
    .RUNS_LOG2 (RUNS_LOG2),
    .SUM_W     (SUM_W),
    .RUN_W     (RUN_W)
  ) u_stats (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .clear     (clear),
    .res_valid (run_valid),
    .res_diff  (run_diff),
    .st_min    (stat_min),
    .st_max    (stat_max),
    .st_sum    (stat_sum),
    .st_runs   (stat_runs),
    .st_spread (stat_spread)
  );

endmodule

// File: tb/tb_gated_edge_stats.sv
`timescale 1ns/1ps
module tb_gated_edge_stats;

  localparam int WIN_W = 16;
  localparam int CNT_W = 17;
  localparam int DIF_W = 18;
  localparam int SUM_W = 34;
  localparam int RUN_W = 17;

  typedef struct {
    longint diff;
    longint cyc;
    string  tag;
  } exp_t;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    div_clk = 1'b0;
  logic                    start = 1'b0;
  logic                    clear = 1'b0;
  logic [WIN_W-1:0]        win_len = '0;
  logic [CNT_W-1:0]        nominal = '0;
  logic signed [DIF_W-1:0] run_diff;
  logic                    run_valid;
  logic signed [DIF_W-1:0] stat_min;
  logic signed [DIF_W-1:0] stat_max;
  logic signed [SUM_W-1:0] stat_sum;
  logic [RUN_W-1:0]        stat_runs;
  logic [DIF_W:0]          stat_spread;

  int     n_cmp = 0;
  int     n_bad = 0;
  longint cyc = 0;
  exp_t   exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gated_edge_stats dut (
    .clk_ref(clk), .rst_n(rst_n), .div_clk(div_clk), .start(start), .clear(clear),
    .win_len(win_len), .nominal(nominal), .run_diff(run_diff), .run_valid(run_valid),
    .stat_min(stat_min), .stat_max(stat_max), .stat_sum(stat_sum),
    .stat_runs(stat_runs), .stat_spread(stat_spread)
  );

  task automatic chk(input string req, input longint act, input longint exp_v);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Monitor: pops one expected item per strobe and compares value and timing.
  always @(negedge clk) begin
    if (rst_n && run_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R5 unexpected result actual=%0d expected=none", $signed(run_diff));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({"R3 diff ", e.tag}, longint'($signed(run_diff)), e.diff);
        chk({"R2 strobe cycle ", e.tag}, cyc, e.cyc);
      end
    end
  end

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      div_clk = 1'b1;
      repeat (2) @(negedge clk);
      div_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  // Driver: opens a window, pushes the expected item, then makes k edges.
  task automatic run(input int len, input int nom, input int k, input bit push, input string tag);
    exp_t e;
    int   eff;
    @(negedge clk);
    eff      = (len == 0) ? 16384 : len;
    win_len  = WIN_W'(len);
    nominal  = CNT_W'(nom);
    start    = 1'b1;
    e.diff   = longint'(k) - longint'(nom);
    e.cyc    = cyc + 1 + eff;
    e.tag    = tag;
    if (push) exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    pulses(k);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_stats(input string req, input longint runs, input longint sum,
                             input longint mn, input longint mx, input longint spr);
    chk({req, " runs"},   longint'(stat_runs), runs);
    chk({req, " sum"},    longint'(stat_sum), sum);
    chk({req, " min"},    longint'(stat_min), mn);
    chk({req, " max"},    longint'(stat_max), mx);
    chk({req, " spread"}, longint'(stat_spread), spr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk("R1 valid", longint'(run_valid), 0);
    chk("R1 diff", longint'(run_diff), 0);
    check_stats("R1", 0, 0, 131071, -131072, 0);

    // R3: positive and negative differences
    run(60, 5, 8, 1, "pos");
    drain();
    run(60, 10, 3, 1, "neg");
    drain();
    run(30, 0, 0, 1, "zero");
    drain();

    // R4: edges while idle are not counted
    pulses(5);
    repeat (4) @(negedge clk);
    run(40, 0, 2, 1, "idle_edges");
    drain();

    // R5: restart abandons the first window
    run(200, 0, 3, 0, "abandoned");
    run(40, 1, 4, 1, "restart");
    drain();
    repeat (250) @(negedge clk);

    // R6: zero length selects the default window
    run(0, 6, 2, 1, "default_len");
    drain();

    // R7, R8: accumulated figures over six runs (3,-7,0,2,3,-4)
    check_stats("R7 R8", 6, -3, -7, 3, 10);

    // R9: plain clear
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check_stats("R9 clear", 0, 0, 131071, -131072, 0);

    // R9: clear colliding with an arriving result
    run(30, 0, 2, 1, "collide");
    while (!run_valid) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    drain();
    check_stats("R9 collide", 0, 0, 131071, -131072, 0);

    // R8: single run gives zero spread
    run(40, 2, 5, 1, "single");
    drain();
    check_stats("R8 single", 1, 3, 3, 3, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule